// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit sits between the load/store stage of a simple in-order core and a single-ported synchronous data memory with a 64-bit data path. It performs read-modify-write atomics as one indivisible sequence. The operations are a byte load-and-set, a 32-bit word exchange, and compare-and-swap at 32 and 64 bits. For every atomic, the response carries the memory value from before the operation, ready for the destination register.

The core presents one request at a time. A request carries an opcode, a byte address, the store operand (`rd`) and the compare operand (`rs2`). An accepted atomic runs through fixed steps:

- The next cycle issues the read beat.
- The cycle after that issues the write beat. On a compare-and-swap mismatch this beat has no write.
- The following cycle presents the response.

A lock output is high from the read beat through the write beat. Other requesters of the memory port use it to stall. Store-barrier and full-barrier requests make no memory access. They wait until the core's count of outstanding stores reaches zero, and then respond one cycle after acceptance.

Memory is big-endian. The byte at offset k within a doubleword occupies data bits [63-8k : 56-8k] and write-enable bit 7-k.

Top module: `amo_unit`

## Requirements
- R1: After reset, `req_ready_o`=1, and `rsp_valid_o`, `mem_req_o`, `mem_we_o` and `mem_lock_o` are all 0.
- R2: Byte load-and-set (opcode 0x0D) writes 0xFF to the addressed byte only, with a single write-enable bit 7-k for offset k. It returns the previous byte zero-extended to 64 bits.
- R3: Word swap (opcode 0x0F) writes `rd[31:0]` to the addressed word and returns the previous word zero-extended. A word at offset 0 occupies bits [63:32] and a word at offset 4 occupies bits [31:0].
- R4: 32-bit compare-and-swap (opcode 0x3C) returns the old word. It writes `rd[31:0]` only when the old word equals `rs2[31:0]`. `rsp_cas_wr_o` is 1 exactly when the write was performed.
- R5: 64-bit compare-and-swap (opcode 0x3E) applies the same rule to the whole doubleword, comparing against `rs2` and writing `rd`.
- R6: An atomic accepted in cycle t issues its read beat in t+1 and its write beat in t+2, and its response is valid in t+3. `mem_lock_o` is 1 in t+1 and t+2.
- R7: A store barrier (opcode 0x30) or full barrier (opcode 0x31) is not accepted while `st_cnt_i` is nonzero. Once accepted, it responds in the next cycle with data 0 and no error, and it makes no memory access.
- R8: A word operation whose address is not 4-byte aligned, or a doubleword operation whose address is not 8-byte aligned, gets an error response in the next cycle. Such a request makes no memory access and leaves memory unchanged.
- R9: Any other opcode gets an error response in the next cycle and makes no memory access.
- R10: The alternate-space forms 0x1D and 0x1F behave exactly like 0x0D and 0x0F.
- R11: `req_ready_o` is 0 from the cycle after an atomic is accepted until its response cycle, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_op_i | input | 6 | Opcode |
| req_addr_i | input | AW | Byte address |
| req_rd_i | input | 64 | Store operand |
| req_rs2_i | input | 64 | Compare operand |
| st_cnt_i | input | CW | Outstanding stores in the core's store path |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_data_o | output | 64 | Pre-operation memory value, zero-extended |
| rsp_err_o | output | 1 | Misaligned or unknown request |
| rsp_cas_wr_o | output | 1 | Compare-and-swap performed its write |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW-3 | Doubleword address |
| mem_be_o | output | 8 | Byte write enables, bit i covers data bits [8i+7:8i] |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, one cycle after the read beat |
| mem_lock_o | output | 1 | Memory port held for an atomic |

## Verification
Two events can fall in the same cycle here. One is a barrier request that is waiting. The other is the outstanding-store count reaching zero. The bench holds a barrier with a nonzero count and checks that ready stays low. It then drops the count to zero while the request is still presented, and expects acceptance on that very edge and a response one cycle later. The bench also presents requests while an atomic is in flight and checks that they are held off until the response beat has passed.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN  = 64;
  localparam int NBYTE = XLEN / 8;
  localparam int OPW   = 6;

  localparam logic [OPW-1:0] OP_LDST     = 6'h0D;
  localparam logic [OPW-1:0] OP_LDST_ALT = 6'h1D;
  localparam logic [OPW-1:0] OP_SWAP     = 6'h0F;
  localparam logic [OPW-1:0] OP_SWAP_ALT = 6'h1F;
  localparam logic [OPW-1:0] OP_CAS32    = 6'h3C;
  localparam logic [OPW-1:0] OP_CAS64    = 6'h3E;
  localparam logic [OPW-1:0] OP_WBAR     = 6'h30;
  localparam logic [OPW-1:0] OP_FBAR     = 6'h31;

  typedef enum logic [2:0] {
    CLS_BAD, CLS_LDST, CLS_SWAP, CLS_CAS32, CLS_CAS64, CLS_BAR
  } amo_cls_e;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_RSP} amo_st_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [2:0]     off_i,
  output amo_cls_e       cls_o,
  output logic           misalign_o
);
  always_comb begin
    unique case (op_i)
      OP_LDST, OP_LDST_ALT: cls_o = CLS_LDST;
      OP_SWAP, OP_SWAP_ALT: cls_o = CLS_SWAP;
      OP_CAS32:             cls_o = CLS_CAS32;
      OP_CAS64:             cls_o = CLS_CAS64;
      OP_WBAR, OP_FBAR:     cls_o = CLS_BAR;
      default:              cls_o = CLS_BAD;
    endcase
  end

  always_comb begin
    unique case (cls_o)
      CLS_SWAP, CLS_CAS32: misalign_o = (off_i[1:0] != 2'b00);
      CLS_CAS64:           misalign_o = (off_i != 3'b000);
      default:             misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/amo_lane.sv
module amo_lane
  import amo_pkg::*;
(
  input  amo_cls_e         cls_i,
  input  logic [2:0]       off_i,
  input  logic [XLEN-1:0]  rdata_i,
  input  logic [XLEN-1:0]  rd_i,
  input  logic [XLEN-1:0]  rs2_i,
  output logic [XLEN-1:0]  old_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic [NBYTE-1:0] be_o,
  output logic             wr_en_o
);
  logic [31:0] word_v;
  logic [7:0]  byte_v;

  // big-endian: offset k lives in lane 7-k
  assign byte_v = rdata_i[{~off_i, 3'b000} +: 8];
  assign word_v = off_i[2] ? rdata_i[31:0] : rdata_i[63:32];

  always_comb begin
    old_o   = '0;
    wdata_o = '0;
    be_o    = '0;
    wr_en_o = 1'b0;
    unique case (cls_i)
      CLS_LDST: begin
        old_o   = {{(XLEN-8){1'b0}}, byte_v};
        wdata_o = {NBYTE{8'hFF}};
        be_o    = NBYTE'(1) << ~off_i;
        wr_en_o = 1'b1;
      end
      CLS_SWAP, CLS_CAS32: begin
        old_o   = {{(XLEN-32){1'b0}}, word_v};
        wdata_o = {rd_i[31:0], rd_i[31:0]};
        be_o    = off_i[2] ? 8'h0F : 8'hF0;
        wr_en_o = (cls_i == CLS_SWAP) || (word_v == rs2_i[31:0]);
      end
      CLS_CAS64: begin
        old_o   = rdata_i;
        wdata_o = rd_i;
        be_o    = '1;
        wr_en_o = (rdata_i == rs2_i);
      end
      default: ;
    endcase
    if (!wr_en_o) be_o = '0;
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fire_i,
  input  logic     short_i,
  output amo_st_e  st_o
);
  amo_st_e st_d;

  always_comb begin
    st_d = st_o;
    unique case (st_o)
      S_IDLE: if (fire_i) st_d = short_i ? S_RSP : S_RD;
      S_RD:   st_d = S_WR;
      S_WR:   st_d = S_RSP;
      S_RSP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= S_IDLE;
    else         st_o <= st_d;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4,
  localparam int MAW = AW - 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [OPW-1:0]   req_op_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [XLEN-1:0]  req_rd_i,
  input  logic [XLEN-1:0]  req_rs2_i,
  input  logic [CW-1:0]    st_cnt_i,
  output logic             rsp_valid_o,
  output logic [XLEN-1:0]  rsp_data_o,
  output logic             rsp_err_o,
  output logic             rsp_cas_wr_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [MAW-1:0]   mem_addr_o,
  output logic [NBYTE-1:0] mem_be_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             mem_lock_o
);
  amo_cls_e        cls_in, cls_q;
  logic            misalign_in, fire, short_in, err_q, cas_wr_q, wr_en;
  logic [AW-1:0]   addr_q;
  logic [XLEN-1:0] rd_q, rs2_q, rsp_q, old_v;
  logic [NBYTE-1:0] be_v;
  amo_st_e         st;

  amo_decode u_dec (
    .op_i(req_op_i), .off_i(req_addr_i[2:0]),
    .cls_o(cls_in), .misalign_o(misalign_in)
  );

  // barriers wait for the store path to drain before acceptance
  assign req_ready_o = (st == S_IDLE) && !(cls_in == CLS_BAR && st_cnt_i != '0);
  assign fire        = req_valid_i && req_ready_o;
  assign short_in    = (cls_in == CLS_BAR) || (cls_in == CLS_BAD) || misalign_in;

  amo_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .short_i(short_in), .st_o(st)
  );

  amo_lane u_lane (
    .cls_i(cls_q), .off_i(addr_q[2:0]), .rdata_i(mem_rdata_i),
    .rd_i(rd_q), .rs2_i(rs2_q),
    .old_o(old_v), .wdata_o(mem_wdata_o), .be_o(be_v), .wr_en_o(wr_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q    <= CLS_BAD;
      addr_q   <= '0;
      rd_q     <= '0;
      rs2_q    <= '0;
      rsp_q    <= '0;
      err_q    <= 1'b0;
      cas_wr_q <= 1'b0;
    end else if (fire) begin
      cls_q    <= cls_in;
      addr_q   <= req_addr_i;
      rd_q     <= req_rd_i;
      rs2_q    <= req_rs2_i;
      rsp_q    <= '0;
      err_q    <= (cls_in == CLS_BAD) || misalign_in;
      cas_wr_q <= 1'b0;
    end else if (st == S_WR) begin
      rsp_q    <= old_v;
      cas_wr_q <= wr_en && (cls_q == CLS_CAS32 || cls_q == CLS_CAS64);
    end
  end

  assign mem_lock_o   = (st == S_RD) || (st == S_WR);
  assign mem_we_o     = (st == S_WR) && wr_en;
  assign mem_req_o    = (st == S_RD) || mem_we_o;
  assign mem_addr_o   = addr_q[AW-1:3];
  assign mem_be_o     = (st == S_WR) ? be_v : '0;
  assign rsp_valid_o  = (st == S_RSP);
  assign rsp_data_o   = rsp_q;
  assign rsp_err_o    = rsp_valid_o && err_q;
  assign rsp_cas_wr_o = rsp_valid_o && cas_wr_q;
endmodule

module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int CW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic [OPW-1:0] req_op_i,
  input logic [CW-1:0]  st_cnt_i,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic           mem_lock_o,
  input logic           rsp_valid_o,
  input logic           rsp_err_o,
  input logic           rsp_cas_wr_o
);
  // R6
  rd_beat_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> mem_lock_o);
  // R6
  rd_to_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> ##2 (rsp_valid_o && !rsp_err_o));
  // R6
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_req_o && !mem_we_o));
  // R11
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o |-> !req_ready_o);
  // R7
  bar_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_op_i == OP_WBAR || req_op_i == OP_FBAR))
      |-> (st_cnt_i == '0));
  // R8
  err_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (!$past(mem_lock_o) && !mem_req_o));
  // R4
  cas_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_cas_wr_o |-> (rsp_valid_o && $past(mem_we_o)));
endmodule

bind amo_unit amo_unit_chk #(.CW(CW)) chk_i (.*);

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  localparam int AW = 16;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_rd = '0, req_rs2 = '0;
  logic [3:0]  st_cnt = '0;
  logic        rsp_valid, rsp_err, rsp_cas_wr;
  logic [63:0] rsp_data;
  logic        mem_req, mem_we, mem_lock;
  logic [12:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;

  logic [63:0] ram [256];
  logic [63:0] exp_mem [256];
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  amo_unit #(.AW(AW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_rd_i(req_rd), .req_rs2_i(req_rs2),
    .st_cnt_i(st_cnt), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_err_o(rsp_err), .rsp_cas_wr_o(rsp_cas_wr), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_lock_o(mem_lock)
  );

  function automatic logic [63:0] pat(int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= pat(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) ram[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= ram[mem_addr[7:0]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // big-endian byte k of a doubleword
  function automatic logic [7:0] get_b(logic [63:0] d, int k);
    return d[63 - 8*k -: 8];
  endfunction

  task automatic atomic(logic [5:0] op, logic [15:0] a, logic [63:0] rd,
                        logic [63:0] rs2, string tag);
    int w = int'(a[10:3]);
    int off = int'(a[2:0]);
    logic [63:0] od = exp_mem[w], nd = exp_mem[w], eold = '0;
    logic ewr = 1'b1, iscas = 1'b0;
    if (op == 6'h0D || op == 6'h1D) begin
      eold = {56'd0, get_b(od, off)};
      nd[63 - 8*off -: 8] = 8'hFF;
    end else if (op == 6'h3E) begin
      eold = od; iscas = 1'b1; ewr = (od == rs2);
      if (ewr) nd = rd;
    end else begin
      for (int b = 0; b < 4; b++) eold = {eold[55:0], get_b(od, off + b)};
      if (op == 6'h3C) begin iscas = 1'b1; ewr = (eold[31:0] == rs2[31:0]); end
      if (ewr) for (int b = 0; b < 4; b++) nd[63 - 8*(off+b) -: 8] = rd[31 - 8*b -: 8];
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_rd = rd; req_rs2 = rs2;
    #1 chk({tag, " R11 ready idle"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    chk({tag, " R6 lock rd beat"}, {mem_lock, mem_req, mem_we, rsp_valid}, 64'b1100);
    chk({tag, " R11 held off"}, 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R6 lock wr beat"}, {mem_lock, rsp_valid}, 64'b10);
    chk({tag, " write beat"}, {mem_req, mem_we}, {62'd0, ewr, ewr});
    @(negedge clk);
    chk({tag, " R6 rsp valid"}, {rsp_valid, rsp_err, mem_lock, req_ready}, 64'b1000);
    chk({tag, " old value"}, rsp_data, eold);
    chk({tag, " R4 cas flag"}, 64'(rsp_cas_wr), 64'(iscas && ewr));
    chk({tag, " memory"}, ram[w], nd);
    exp_mem[w] = nd;
  endtask

  task automatic short_req(logic [5:0] op, logic [15:0] a, logic eerr, string tag);
    int w = int'(a[10:3]);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a;
    #1 chk({tag, " ready"}, 64'(req_ready), 64'd1);
    chk({tag, " no access at accept"}, 64'(mem_req), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp"}, {rsp_valid, rsp_err, mem_req, mem_lock}, {60'd0, 1'b1, eerr, 2'b00});
    chk({tag, " rsp data"}, rsp_data, 64'd0);
    chk({tag, " memory untouched"}, ram[w], exp_mem[w]);
    @(negedge clk);
  endtask

  task automatic barrier(logic [5:0] op, string tag);
    @(negedge clk);
    st_cnt = 4'd2; req_valid = 1'b1; req_op = op;
    for (int i = 0; i < 3; i++) begin
      #1 chk({tag, " R7 stalled"}, {req_ready, mem_req}, 64'd0);
      @(negedge clk);
    end
    st_cnt = 4'd0;
    #1 chk({tag, " R7 accept on drain"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R7 rsp"}, {rsp_valid, rsp_err, rsp_cas_wr, mem_req}, 64'b1000);
    chk({tag, " R7 data"}, rsp_data, 64'd0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset state", {req_ready, rsp_valid, mem_req, mem_we, mem_lock}, 64'b10000);
    // R2 / R10 byte load-and-set at offsets 0, 5, 7 and repeat
    atomic(6'h0D, 16'h0010, '0, '0, "R2 ldst off0");
    atomic(6'h1D, 16'h002D, '0, '0, "R10 R2 ldst off5");
    atomic(6'h0D, 16'h0037, '0, '0, "R2 ldst off7");
    atomic(6'h0D, 16'h0010, '0, '0, "R2 ldst again");
    // R3 / R10 swap, both halves
    atomic(6'h0F, 16'h0040, 64'hFFFF_FFFF_DEAD_BEEF, '0, "R3 swap hi");
    atomic(6'h1F, 16'h004C, 64'h0000_0000_CAFE_F00D, '0, "R10 R3 swap lo");
    // R4 cas32 match and mismatch
    atomic(6'h3C, 16'h0060, 64'h1111_2222, {32'hAAAA_AAAA, exp_mem[12][63:32]}, "R4 cas32 hit");
    atomic(6'h3C, 16'h0064, 64'h3333_4444, 64'h0, "R4 cas32 miss");
    // R5 cas64 match and mismatch
    atomic(6'h3E, 16'h0080, 64'h5555_6666_7777_8888, exp_mem[16], "R5 cas64 hit");
    atomic(6'h3E, 16'h0088, 64'h9999, ~exp_mem[17], "R5 cas64 miss");
    // R8 misaligned
    short_req(6'h0F, 16'h0042, 1'b1, "R8 swap misalign");
    short_req(6'h3C, 16'h0066, 1'b1, "R8 cas32 misalign");
    short_req(6'h3E, 16'h0084, 1'b1, "R8 cas64 misalign");
    // R9 unknown opcode
    short_req(6'h05, 16'h0090, 1'b1, "R9 bad opcode");
    // R7 barriers
    barrier(6'h30, "store barrier");
    barrier(6'h31, "full barrier");
    atomic(6'h3C, 16'h00A4, 64'h7, {32'd0, exp_mem[20][31:0]}, "R6 R4 after barrier");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule